// File: doc/BRIEF.md
# Pulse Width Generator with Register Bus

This block produces one pulse-width-modulated output whose cycle length and active time are set through four 32-bit registers on a simple write/read bus. A free-running counter advances once every `PRESCALE` input clocks while the channel runs. It returns to zero after reaching the programmed cycle length minus one. The output sits at its active level while the counter is below the programmed active count, and at the opposite level for the rest of the cycle. While the channel is stopped, the output rests at a separately programmed idle level.

Software sets the cycle length and the active count, then sets the run bit. It can restart the current cycle at any time by writing zero to the counter. Length and active count written while the channel runs are held back until the counter wraps, so no cycle is ever cut short or stretched by an update. The prescale divider is a synthesis-time parameter and is usually set to 1 or 2.

Top module: `pulse_width_unit`

## Requirements
- R1: After reset the output is low and all four registers read 0.
- R2: Registers sit at byte offsets 0x0 (counter), 0x4 (cycle length), 0x8 (active count) and 0xC (control). A read returns on `bus_rdata` one clock after `bus_addr` is presented. Length and active count read back as written. Control keeps only bits 0, 1, 3, 4, 5 and 8 and reads 0 in every other bit. Bits 1, 5 and 8 are stored but have no effect on the output.
- R3: A write to any address other than the four offsets changes no register.
- R4: While control bit 0 (run) is 0, the counter reads 0 and the output equals control bit 4 (1 = rest high, 0 = rest low).
- R5: While run is 1, the counter advances by one every `PRESCALE` clocks, reads live, and stays below the active cycle length.
- R6: While run is 1, the output is at the active level while counter < active count, and at the opposite level otherwise. Control bit 3 gives the active level (1 = high, 0 = low).
- R7: An active count of 0 holds the output at the non-active level for the whole cycle. An active count greater than or equal to the cycle length holds it at the active level for the whole cycle.
- R8: Length or active count written while running take effect only when the counter wraps. While stopped, the values written are used from the first cycle.
- R9: A write to the counter while running loads the written value and restarts the prescale phase. Writing 0 restarts the cycle, so an immediate read returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | ADDR_W | Byte offset for the read or write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| pwm_out | output | 1 | Registered pulse-width output |

## Verification
The counter bound and the mid-cycle stability of the held length and active count assume that software never writes a counter value at or above the current cycle length while running. The stimulus therefore writes only 0 to the counter. The full-cycle output checks assume a nonzero cycle length, and every stimulus vector uses a length of at least 1. Updates made while running are checked at the output, which must keep the old active count until the wrap.

// File: rtl/pulse_width_pkg.sv
package pulse_width_pkg;
  // Byte offsets seen by software; decoded by the register block.
  localparam int OFS_COUNT  = 'h0;
  localparam int OFS_LENGTH = 'h4;
  localparam int OFS_ACTIVE = 'h8;
  localparam int OFS_CTRL   = 'hC;

  // Control bit positions.
  localparam int CB_RUN     = 0;
  localparam int CB_FREE    = 1;
  localparam int CB_ACT_HI  = 3;
  localparam int CB_IDLE_HI = 4;
  localparam int CB_ALIGN   = 5;
  localparam int CB_LOWPWR  = 8;
  localparam int CTRL_W     = 9;

  localparam logic [CTRL_W-1:0] CTRL_KEEP =
    CTRL_W'((1 << CB_RUN) | (1 << CB_FREE) | (1 << CB_ACT_HI) |
            (1 << CB_IDLE_HI) | (1 << CB_ALIGN) | (1 << CB_LOWPWR));
endpackage

// File: rtl/pulse_width_regs.sv
module pulse_width_regs
  import pulse_width_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] cnt_live,
  output logic [DATA_W-1:0] length_q,
  output logic [DATA_W-1:0] active_q,
  output logic              run,
  output logic              act_hi,
  output logic              idle_hi,
  output logic              cnt_wr,
  output logic [DATA_W-1:0] bus_rdata
);
  logic [CTRL_W-1:0] ctrl_q;

  logic hit_count, hit_length, hit_active, hit_ctrl;
  assign hit_count  = (bus_addr == ADDR_W'(OFS_COUNT));
  assign hit_length = (bus_addr == ADDR_W'(OFS_LENGTH));
  assign hit_active = (bus_addr == ADDR_W'(OFS_ACTIVE));
  assign hit_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));

  assign cnt_wr = bus_wr && hit_count;

  always_ff @(posedge clk) begin
    if (rst) begin
      length_q <= '0;
      active_q <= '0;
      ctrl_q   <= '0;
    end else if (bus_wr) begin
      if (hit_length) length_q <= bus_wdata;
      if (hit_active) active_q <= bus_wdata;
      if (hit_ctrl)   ctrl_q   <= bus_wdata[CTRL_W-1:0] & CTRL_KEEP;
    end
  end

  assign run     = ctrl_q[CB_RUN];
  assign act_hi  = ctrl_q[CB_ACT_HI];
  assign idle_hi = ctrl_q[CB_IDLE_HI];

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_count)  rd_mux = cnt_live;
    if (hit_length) rd_mux = length_q;
    if (hit_active) rd_mux = active_q;
    if (hit_ctrl)   rd_mux = DATA_W'(ctrl_q);
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/pulse_width_prescale.sv
module pulse_width_prescale #(
  parameter int PRESCALE = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] phase;

  assign tick = run && (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || restart || tick) phase <= '0;
    else                                phase <= phase + 1'b1;
  end
endmodule

// File: rtl/pulse_width_core.sv
module pulse_width_core #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tick,
  input  logic              cnt_wr,
  input  logic [DATA_W-1:0] cnt_wdata,
  input  logic [DATA_W-1:0] length_q,
  input  logic [DATA_W-1:0] active_q,
  input  logic              act_hi,
  input  logic              idle_hi,
  output logic [DATA_W-1:0] cnt_val,
  output logic [DATA_W-1:0] len_sh,
  output logic [DATA_W-1:0] act_sh,
  output logic              wrap,
  output logic              pwm_out
);
  logic at_end;
  logic in_active;

  assign at_end    = (len_sh == '0) || (cnt_val >= len_sh - 1'b1);
  assign wrap      = tick && at_end;
  assign in_active = (cnt_val < act_sh);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_val <= '0;
      len_sh  <= '0;
      act_sh  <= '0;
      pwm_out <= 1'b0;
    end else begin
      if (!run)        cnt_val <= '0;
      else if (cnt_wr) cnt_val <= cnt_wdata;
      else if (wrap)   cnt_val <= '0;
      else if (tick)   cnt_val <= cnt_val + 1'b1;

      if (!run || wrap) begin
        len_sh <= length_q;
        act_sh <= active_q;
      end

      if (run) pwm_out <= in_active ? act_hi : ~act_hi;
      else     pwm_out <= idle_hi;
    end
  end
endmodule

// File: rtl/pulse_width_unit.sv
module pulse_width_unit #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int PRESCALE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);
  logic [DATA_W-1:0] length_q, active_q, cnt_val, len_sh, act_sh;
  logic run, act_hi, idle_hi, cnt_wr, tick, wrap;

  pulse_width_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cnt_live(cnt_val), .length_q(length_q),
    .active_q(active_q), .run(run), .act_hi(act_hi), .idle_hi(idle_hi),
    .cnt_wr(cnt_wr), .bus_rdata(bus_rdata)
  );

  pulse_width_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .run(run), .restart(cnt_wr), .tick(tick)
  );

  pulse_width_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .cnt_wr(cnt_wr),
    .cnt_wdata(bus_wdata), .length_q(length_q), .active_q(active_q),
    .act_hi(act_hi), .idle_hi(idle_hi), .cnt_val(cnt_val),
    .len_sh(len_sh), .act_sh(act_sh), .wrap(wrap), .pwm_out(pwm_out)
  );
endmodule

// File: rtl/pulse_width_unit_chk.sv
module pulse_width_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              act_hi,
  input logic              idle_hi,
  input logic [DATA_W-1:0] cnt_val,
  input logic [DATA_W-1:0] len_sh,
  input logic [DATA_W-1:0] act_sh,
  input logic              wrap,
  input logic              pwm_out
);
  // R4: a stopped channel drives the idle level on the next clock
  assert_idle_level_R4: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pwm_out == $past(idle_hi)));

  // R4: a channel that just started begins from counter zero
  assert_start_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (run && !$past(run)) |-> (cnt_val == '0));

  // R5: counter stays inside the held cycle length
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (run && len_sh != '0) |-> (cnt_val < len_sh));

  // R7: zero active count never shows the active level
  assert_zero_active_R7: assert property (@(posedge clk) disable iff (rst)
    (run && act_sh == '0) |=> (pwm_out == !$past(act_hi)));

  // R7: active count covering the cycle always shows the active level
  assert_full_active_R7: assert property (@(posedge clk) disable iff (rst)
    (run && len_sh != '0 && act_sh >= len_sh) |=> (pwm_out == $past(act_hi)));

  // R8: held length and active count change only at a wrap
  assert_hold_midcycle_R8: assert property (@(posedge clk) disable iff (rst)
    (run && !wrap) |=> ($stable(len_sh) && $stable(act_sh)));
endmodule

bind pulse_width_unit pulse_width_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .run(run), .act_hi(act_hi), .idle_hi(idle_hi),
  .cnt_val(cnt_val), .len_sh(len_sh), .act_sh(act_sh), .wrap(wrap),
  .pwm_out(pwm_out)
);

// File: tb/pulse_width_unit_bench.sv
`timescale 1ns/1ps
module pulse_width_unit_bench;
  localparam int AW  = 4;
  localparam int DW  = 32;
  localparam int DIV = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic pwm_out;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  pulse_width_unit #(.ADDR_W(AW), .DATA_W(DW), .PRESCALE(DIV)) u_pulse_width_unit (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  // length, active count, control word, expected active-high ticks per cycle
  localparam int NV = 9;
  localparam logic [31:0] VEC [NV][4] = '{
    '{32'd10, 32'd3,  32'h0B, 32'd3},
    '{32'd10, 32'd3,  32'h03, 32'd7},
    '{32'd8,  32'd0,  32'h0B, 32'd0},
    '{32'd8,  32'd0,  32'h03, 32'd8},
    '{32'd6,  32'd6,  32'h0B, 32'd6},
    '{32'd6,  32'd9,  32'h0B, 32'd6},
    '{32'd5,  32'd9,  32'h03, 32'd0},
    '{32'd1,  32'd1,  32'h0B, 32'd1},
    '{32'd12, 32'd11, 32'h2B, 32'd11}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic count_high(input int cycles, output int highs);
    highs = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwm_out) highs++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] v, v2;
    int h;
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: reset state
    check("R1 out", {31'd0, pwm_out}, 32'd0);
    rd(4'h0, v); check("R1 counter", v, 0);
    rd(4'h4, v); check("R1 length", v, 0);
    rd(4'h8, v); check("R1 active", v, 0);
    rd(4'hC, v); check("R1 ctrl", v, 0);

    // R2: readback and control mask
    wr(4'h4, 32'hDEAD_BEEF); rd(4'h4, v); check("R2 length", v, 32'hDEAD_BEEF);
    wr(4'h8, 32'h1234_5678); rd(4'h8, v); check("R2 active", v, 32'h1234_5678);
    wr(4'hC, 32'hFFFF_FFFF); rd(4'hC, v); check("R2 ctrl mask", v, 32'h13B);
    wr(4'hC, 32'h0);

    // R3: unmapped write ignored
    wr(4'h6, 32'h55); rd(4'h4, v); check("R3 length kept", v, 32'hDEAD_BEEF);
    rd(4'h8, v); check("R3 active kept", v, 32'h1234_5678);

    // R4: idle levels while stopped, counter write ignored
    wr(4'hC, 32'h18); repeat (2) @(negedge clk);
    check("R4 idle high", {31'd0, pwm_out}, 1);
    wr(4'hC, 32'h08); repeat (2) @(negedge clk);
    check("R4 idle low", {31'd0, pwm_out}, 0);
    wr(4'h0, 32'd77); rd(4'h0, v); check("R4 counter held", v, 0);

    // R6 R7: vector table
    for (int k = 0; k < NV; k++) begin
      wr(4'hC, 32'h0);
      wr(4'h4, VEC[k][0]);
      wr(4'h8, VEC[k][1]);
      wr(4'hC, VEC[k][2]);
      repeat (2 * DIV * VEC[k][0] + 4) @(negedge clk);
      count_high(4 * DIV * int'(VEC[k][0]), h);
      check($sformatf("R6 R7 vector %0d", k), h, 4 * DIV * VEC[k][3]);
    end

    // R5 R9: live counter and restart
    wr(4'hC, 32'h0);
    wr(4'h4, 32'd1000); wr(4'h8, 32'd10); wr(4'hC, 32'h0B);
    repeat (600) @(negedge clk);
    wr(4'h0, 32'd0);
    rd(4'h0, v); check("R9 restart reads 0", v, 0);
    rd(4'h0, v);
    repeat (98) @(negedge clk);
    rd(4'h0, v2);
    check("R5 counter advance", v2 - v, 32'd100 / DIV);

    // R8: update while running waits for the wrap
    wr(4'hC, 32'h0);
    wr(4'h4, 32'd200); wr(4'h8, 32'd50); wr(4'hC, 32'h0B);
    repeat (10) @(negedge clk);
    wr(4'h0, 32'd0);
    repeat (200) @(negedge clk);
    wr(4'h8, 32'd150);
    count_high(160, h);
    check("R8 old active count held", h, 0);
    repeat (400) @(negedge clk);
    count_high(400, h);
    check("R8 new active count used", h, 150 * DIV);

    // R4: stopping returns to the idle level
    wr(4'hC, 32'h10); repeat (2) @(negedge clk);
    check("R4 stop idle high", {31'd0, pwm_out}, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule